// File: doc/BRIEF.md
# I2C SCL Clock Waveform Generator

This block times the low and high halves of the I2C serial clock for a bus master. It counts system clock cycles and drives a registered SCL level request to the bit engine. It also raises a strobe for one cycle whenever that level changes.

The timing comes from a single divider word. The word holds a divisor for the low half, a divisor for the high half and a shared power-of-two prescale exponent. Each half lasts its divisor shifted left by the exponent, plus a fixed offset that depends on the implementation variant. The exponent has a variant-dependent ceiling, and a larger programmed exponent is reduced to that ceiling.

The bit engine controls the generator with two inputs. Clearing the enable parks SCL high. Raising the hold input freezes SCL low, so the engine can stretch the clock. When either condition is released, the generator counts a fresh, full phase from zero. A new divider word takes effect only when the next phase starts.

Top module: `i2c_scl_waveform`

## Requirements
- R1: While running, each low phase lasts exactly `lo × 2^e + OFFSET` system clocks. The low divisor `lo` is taken from divider word bits 7:0, and the exponent `e` from bits 18:16.
- R2: While running, each high phase lasts exactly `hi × 2^e + OFFSET` system clocks. The high divisor `hi` is taken from word bits 15:8 and uses the same exponent `e`. When `hi` equals `lo`, the full SCL period is twice one phase.
- R3: A programmed exponent above `MAX_EXP` is treated as `MAX_EXP`. With the default `MAX_EXP` of 5, an exponent field of 7 behaves as 5.
- R4: A divisor of zero gives a phase of exactly `OFFSET` cycles (3 by default). No phase is ever shorter than one cycle.
- R5: The length of a phase is fixed when that phase begins. A divider word written mid-phase affects only the phases that start after it.
- R6: With enable low, SCL is requested high and no strobe is produced. After enable rises, the first high phase lasts its full length, counted from the first enabled cycle.
- R7: With enable high and hold high, SCL is requested low from the next cycle onward. After hold is released, a full low phase is counted from zero, and then SCL goes high.
- R8: `phase_tick_o` is high for exactly the one cycle in which `scl_level_o` has just changed, for both counted and forced changes.
- R9: After reset, `scl_level_o` is high and `phase_tick_o` is low.
- R10: Enable low takes priority over hold. With enable low, SCL stays high even while hold is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Run the generator; low parks SCL high |
| hold_i | input | 1 | Freeze SCL low while enabled |
| div_word_i | input | 19 | {exponent[18:16], high divisor[15:8], low divisor[7:0]} |
| scl_level_o | output | 1 | Requested SCL level (1 = released high) |
| phase_tick_o | output | 1 | One-cycle strobe on every SCL level change |

## Verification
The bench measures every completed phase between two strobes against lengths computed from the formula. Several cases catch specific faults:
- A divider word written in the middle of a low phase: a design that reloads immediately stretches or cuts that phase.
- A clamped exponent of 7: without the clamp, the phase is four times too long.
- Zero divisors: these reveal an off-by-one in the terminal count.
- Hold and enable releases, timed from the release edge: a counter that is not cleared on release produces a short first phase.
- Hold asserted while disabled: if hold wins that contest, SCL drops although it should stay high.
- Forced changes: a design that strobes only on counted transitions leaves these silent.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_RUN  = 2'd2
    } gen_mode_e;

endpackage

// File: rtl/sclgen_len_calc.sv
module sclgen_len_calc #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 5,
    parameter int OFFSET  = 3,
    parameter int CNT_W   = 13,
    localparam int WORD_W = 2 * DIV_W + EXP_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [CNT_W-1:0]  lo_len_o,
    output logic [CNT_W-1:0]  hi_len_o
);

    logic [DIV_W-1:0] lo_div;
    logic [DIV_W-1:0] hi_div;
    logic [EXP_W-1:0] exp_raw;
    logic [EXP_W-1:0] exp_eff;

    assign lo_div  = word_i[DIV_W-1:0];
    assign hi_div  = word_i[2*DIV_W-1:DIV_W];
    assign exp_raw = word_i[WORD_W-1:2*DIV_W];

    // Clamp only when the field can encode values above the ceiling.
    generate
        if (((1 << EXP_W) - 1) > MAX_EXP) begin : g_clamp
            assign exp_eff = (exp_raw > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_raw;
        end else begin : g_pass
            assign exp_eff = exp_raw;
        end
    endgenerate

    function automatic logic [CNT_W-1:0] phase_len(input logic [DIV_W-1:0] div,
                                                   input logic [EXP_W-1:0] ex);
        logic [CNT_W-1:0] t;
        t = (CNT_W'(div) << ex) + CNT_W'(OFFSET);
        if (t == '0) begin
            t = CNT_W'(1);
        end
        return t;
    endfunction

    always_comb begin
        lo_len_o = phase_len(lo_div, exp_eff);
        hi_len_o = phase_len(hi_div, exp_eff);
    end

endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] lo_len_i,
    input  logic [CNT_W-1:0] hi_len_i,
    output logic             scl_o,
    output logic             tick_o
);

    typedef struct packed {
        logic             scl;
        logic             tick;
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
    } gen_state_t;

    gen_state_t st_d, st_q;
    gen_mode_e  mode;
    logic [CNT_W-1:0] cur_len;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;

        if (!enable_i) begin
            mode = MODE_IDLE;
        end else if (hold_i) begin
            mode = MODE_HOLD;
        end else begin
            mode = MODE_RUN;
        end

        // On the first running cycle the length comes live from the word.
        cur_len = st_q.run ? st_q.len : (st_q.scl ? hi_len_i : lo_len_i);

        case (mode)
            MODE_IDLE: begin
                st_d.scl = 1'b1;
                st_d.cnt = '0;
                st_d.run = 1'b0;
            end
            MODE_HOLD: begin
                st_d.scl = 1'b0;
                st_d.cnt = '0;
                st_d.run = 1'b0;
            end
            default: begin
                st_d.run = 1'b1;
                st_d.len = cur_len;
                if ((st_q.cnt + CNT_W'(1)) >= cur_len) begin
                    st_d.scl = ~st_q.scl;
                    st_d.cnt = '0;
                    st_d.len = st_q.scl ? lo_len_i : hi_len_i;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        endcase

        st_d.tick = (st_d.scl != st_q.scl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{scl: 1'b1, tick: 1'b0, run: 1'b0, cnt: '0, len: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o  = st_q.scl;
    assign tick_o = st_q.tick;

endmodule

// File: rtl/i2c_scl_waveform.sv
module i2c_scl_waveform #(
    parameter int DIV_W   = 8,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 5,
    parameter int OFFSET  = 3,
    localparam int WORD_W    = 2 * DIV_W + EXP_W,
    localparam int MAX_PHASE = ((1 << DIV_W) - 1) * (1 << MAX_EXP) + OFFSET,
    localparam int CNT_W     = $clog2(MAX_PHASE + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] div_word_i,
    output logic              scl_level_o,
    output logic              phase_tick_o
);

    logic [CNT_W-1:0] lo_len;
    logic [CNT_W-1:0] hi_len;

    sclgen_len_calc #(
        .DIV_W  (DIV_W),
        .EXP_W  (EXP_W),
        .MAX_EXP(MAX_EXP),
        .OFFSET (OFFSET),
        .CNT_W  (CNT_W)
    ) u_len_calc (
        .word_i  (div_word_i),
        .lo_len_o(lo_len),
        .hi_len_o(hi_len)
    );

    sclgen_phase_fsm #(
        .CNT_W(CNT_W)
    ) u_phase_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(enable_i),
        .hold_i  (hold_i),
        .lo_len_i(lo_len),
        .hi_len_i(hi_len),
        .scl_o   (scl_level_o),
        .tick_o  (phase_tick_o)
    );

endmodule

// File: rtl/i2c_scl_waveform_chk.sv
module i2c_scl_waveform_chk #(
    parameter int DIV_W   = 8,
    parameter int MAX_EXP = 5,
    parameter int OFFSET  = 3,
    localparam int MAX_PHASE = ((1 << DIV_W) - 1) * (1 << MAX_EXP) + OFFSET,
    localparam int RUN_W     = $clog2(MAX_PHASE + 4)
) (
    input logic clk,
    input logic rst_n,
    input logic enable_i,
    input logic hold_i,
    input logic scl_level_o,
    input logic phase_tick_o
);

    // Counts running cycles since the last level change.
    logic [RUN_W-1:0] run_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt_q <= '0;
        end else if (!enable_i || hold_i || phase_tick_o) begin
            run_cnt_q <= '0;
        end else if (run_cnt_q <= RUN_W'(MAX_PHASE)) begin
            run_cnt_q <= run_cnt_q + RUN_W'(1);
        end
    end

    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt_q <= RUN_W'(MAX_PHASE));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !$past(enable_i)) |=> !phase_tick_o);

    assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && hold_i) |=> !scl_level_o);

    assert_tick_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_tick_o == (scl_level_o != $past(scl_level_o)));

    assert_disable_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && hold_i) |=> scl_level_o);

endmodule

bind i2c_scl_waveform i2c_scl_waveform_chk #(
    .DIV_W  (DIV_W),
    .MAX_EXP(MAX_EXP),
    .OFFSET (OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .hold_i      (hold_i),
    .scl_level_o (scl_level_o),
    .phase_tick_o(phase_tick_o)
);

// File: tb/i2c_scl_waveform_bench.sv
module i2c_scl_waveform_bench;

    localparam int OFFS = 3;
    localparam int MAXE = 5;

    typedef struct {
        logic  level;
        int    len;
        string req;
    } phase_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hold = 1'b0;
    logic [18:0] word = '0;
    logic        scl;
    logic        tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    phase_t exp_q[$];

    always #2 clk = ~clk;

    i2c_scl_waveform u_i2c_scl_waveform (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable),
        .hold_i      (hold),
        .div_word_i  (word),
        .scl_level_o (scl),
        .phase_tick_o(tick)
    );

    function automatic int plen(input int div, input int e);
        int ee;
        ee = (e > MAXE) ? MAXE : e;
        return div * (1 << ee) + OFFS;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic set_word(input int lo, input int hi, input int e);
        word = {3'(e), 8'(hi), 8'(lo)};
    endtask

    task automatic push(input logic lvl, input int len, input string req);
        phase_t p;
        p.level = lvl;
        p.len   = len;
        p.req   = req;
        exp_q.push_back(p);
    endtask

    // Monitor: measures every phase between two strobes.
    int run_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            run_len++;
            if (tick) begin
                if (exp_q.size() > 0) begin
                    phase_t p;
                    p = exp_q.pop_front();
                    chk({p.req, " level"}, int'(!scl), int'(p.level));
                    chk({p.req, " length"}, run_len, p.len);
                end
                run_len = 0;
            end
        end
    end

    // Counts negedges from a release until the first strobe.
    task automatic measure_first(input int expv, input string req);
        int k;
        k = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            k++;
            if (tick) break;
        end
        chk(req, k, expv);
        #1;
    endtask

    task automatic wait_tick_at(input logic lvl);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (tick && scl == lvl) break;
        end
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 40000; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        chk("queue drained", exp_q.size(), 0);
    endtask

    task automatic quiet_window(input int n, input logic lvl, input string req);
        int ticks;
        int bad;
        ticks = 0;
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick) ticks++;
            if (scl != lvl) bad++;
        end
        chk({req, " strobes"}, ticks, 0);
        chk({req, " level"}, bad, 0);
    endtask

    task automatic run_config(input int lo, input int hi, input int e, input string req);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        set_word(lo, hi, e);
        enable = 1'b1;
        measure_first(plen(hi, e), {req, " first high R6"});
        push(1'b0, plen(lo, e), {req, " low"});
        push(1'b1, plen(hi, e), {req, " high"});
        push(1'b0, plen(lo, e), {req, " low"});
        push(1'b1, plen(hi, e), {req, " high"});
        wait_drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 scl after reset", int'(scl), 1);
        chk("R9 tick after reset", int'(tick), 0);
        rst_n = 1'b1;

        // R6: idle high, quiet
        quiet_window(10, 1'b1, "R6 idle");

        // R1/R2: equal divisors, period is twice one phase
        set_word(2, 2, 0);
        enable = 1'b1;
        measure_first(plen(2, 0), "R6 first high");
        push(1'b0, 5, "R1 equal low");
        push(1'b1, 5, "R2 equal high");
        push(1'b0, 5, "R1 equal low");
        push(1'b1, 5, "R2 equal high");
        wait_drain();

        // R5: word change in the middle of a low phase
        wait_tick_at(1'b0);
        #1;
        push(1'b0, 5, "R5 old low kept");
        push(1'b1, plen(6, 0), "R5 new high");
        push(1'b0, plen(4, 0), "R5 new low");
        @(negedge clk);
        @(negedge clk);
        set_word(4, 6, 0);
        wait_drain();

        // R7/R8: hold during a high phase
        wait_tick_at(1'b1);
        hold = 1'b1;
        @(negedge clk);
        chk("R7 scl forced low", int'(scl), 0);
        chk("R8 strobe on forced fall", int'(tick), 1);
        quiet_window(20, 1'b0, "R7 held");
        hold = 1'b0;
        measure_first(plen(4, 0), "R7 low after release");
        chk("R7 scl high after low phase", int'(scl), 1);

        // R6/R8/R10: disable during a low phase, then hold while disabled
        wait_tick_at(1'b0);
        enable = 1'b0;
        @(negedge clk);
        chk("R6 scl parked high", int'(scl), 1);
        chk("R8 strobe on forced rise", int'(tick), 1);
        hold = 1'b1;
        quiet_window(15, 1'b1, "R10 disabled with hold");
        hold = 1'b0;

        // R1/R2: distinct divisors with exponent
        run_config(3, 1, 2, "R1 R2 distinct");
        // R3: exponent 7 clamped to 5
        run_config(1, 2, 7, "R3 clamp");
        // R4: zero divisors give offset-only phases
        run_config(0, 0, 3, "R4 zero");
        // R1: widest low divisor
        run_config(255, 0, 0, "R1 wide");

        enable = 1'b0;
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule